// File: doc/BRIEF.md
# PCI Interrupt Line Router

The router takes a small set of shared PCI interrupt lines and steers each one onto a selectable legacy IRQ input of an interrupt controller. The lines are active low and level sensitive, so several boards may pull the same line. A routed line is inverted and reaches the controller as an active-high level. An on-chip source, such as a power-management or watchdog event, signals by pulling its own PCI line low through an open-drain driver. The value read back from the pad is then routed like that of any external device.

Software writes a routing byte per line and a per-IRQ edge/level control word through a single-cycle synchronous write port. A line must only be routed to an IRQ that is set to level mode, and the block flags any enabled route that targets an edge-mode IRQ. Requests from the serial IRQ decoder are merged per IRQ. An IRQ that carries a PCI interrupt refuses serial requests from active-high devices, but it still accepts them from active-low devices that can share the line. All interrupt inputs pass through two synchronizer flops. The merged IRQ vector is registered.

Top module: `pirq_router`

## Requirements
- R1: After reset, every route is disabled, every IRQ control bit is 0 (edge mode), and irq_o, route_err_o and pirq_drv_o are all 0.
- R2: A low level on a PCI line whose route is enabled to a non-reserved IRQ t sets irq_o[t] to 1. A high level leaves it at 0.
- R3: Write addresses 0 to 3 hold the routing bytes of lines A to D. In each byte, bit 7 = 1 disables the route and bits 3:0 give the IRQ number. A disabled route contributes nothing to irq_o.
- R4: IRQs 0, 1, 2, 8 and 13 are reserved. A route that names one of them has no effect. Serial requests on a reserved IRQ always pass.
- R5: Lines routed to the same IRQ are ORed, so any one of them held low asserts that IRQ.
- R6: int_src_i[i] = 1 sets pirq_drv_o[i] = 1 (pull line i low). The resulting pad level is routed like an external request.
- R7: An active-high serial request (ser_req_i[k] = 1 with ser_low_i[k] = 0) passes to irq_o[k] only if no enabled route targets IRQ k. The line level of that route does not matter.
- R8: A serial request from an active-low device (ser_low_i[k] = 1) passes to irq_o[k] even when a route targets IRQ k.
- R9: Write address 4 loads control bits for IRQs 7:0 and address 5 loads those for IRQs 15:8. A bit value of 1 means level mode.
- R10: route_err_o[i] is 1 exactly when route i is enabled, targets a non-reserved IRQ, and that IRQ's control bit is 0.
- R11: A change on pirq_n_i or ser_req_i reaches irq_o on the third rising clock edge. A routing write changes irq_o on the edge after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select: 0-3 routes, 4-5 edge/level control |
| wr_data_i | input | 8 | Write data |
| pirq_n_i | input | NUM_LINES | PCI interrupt line levels from the pads, active low |
| int_src_i | input | NUM_LINES | On-chip interrupt sources, one per line, active high |
| pirq_drv_o | output | NUM_LINES | Open-drain pull-down enable for each line |
| ser_req_i | input | 16 | Serial IRQ requests per IRQ, active high |
| ser_low_i | input | 16 | Per IRQ: 1 when the serial device is active-low sharable |
| irq_o | output | 16 | Active-high IRQ levels toward the interrupt controller |
| route_err_o | output | NUM_LINES | Enabled route targets an edge-mode IRQ |

## Verification
The function that collides is the claim of an IRQ by a PCI route against a serial request arriving on the same IRQ in the same cycle. The bench routes two lines onto one IRQ and a third line onto another. It then applies serial requests of both polarities on those IRQs, with the lines both idle and pulled low. For each combination it judges whether the request was withheld or merged. Reserved IRQs and untargeted IRQs serve as controls. In those cases the request must pass regardless of what the routing registers name.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int IRQ_N = 16;
  localparam int IRQ_W = $clog2(IRQ_N);
  // IRQ 0,1,2,8,13 never accept a PCI route
  localparam logic [IRQ_N-1:0] RSVD_MASK = 16'h2107;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTL_LO = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CTL_HI = 3'd5;

  typedef struct packed {
    logic             dis;
    logic [IRQ_W-1:0] num;
  } route_t;
endpackage

// File: rtl/pirq_sync.sv
module pirq_sync #(
  parameter int          W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [7:0]                    wr_data_i,
  output route_t [NUM_LINES-1:0]        routes_o,
  output logic   [IRQ_N-1:0]            ctl_o
);
  route_t [NUM_LINES-1:0] routes_q;
  logic   [IRQ_N-1:0]     ctl_q;
  logic   [2:0]           unused_wr_bits;

  assign unused_wr_bits = wr_data_i[6:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_LINES; i++) routes_q[i] <= '{dis: 1'b1, num: '0};
      ctl_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < NUM_LINES; i++)
        if (wr_addr_i == ADDR_W'(i)) routes_q[i] <= '{dis: wr_data_i[7], num: wr_data_i[IRQ_W-1:0]};
      if (wr_addr_i == ADDR_CTL_LO) ctl_q[7:0]  <= wr_data_i;
      if (wr_addr_i == ADDR_CTL_HI) ctl_q[15:8] <= wr_data_i;
    end
  end

  assign routes_o = routes_q;
  assign ctl_o    = ctl_q;

  AST_CTL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(ctl_q)); // R9
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  route_t [NUM_LINES-1:0] routes_i,
  input  logic   [IRQ_N-1:0]     ctl_i,
  input  logic   [NUM_LINES-1:0] line_n_i,
  input  logic   [IRQ_N-1:0]     ser_req_i,
  input  logic   [IRQ_N-1:0]     ser_low_i,
  output logic   [IRQ_N-1:0]     irq_o,
  output logic   [NUM_LINES-1:0] err_o
);
  logic [NUM_LINES-1:0] route_en;
  logic [IRQ_N-1:0]     taken, hit, irq_d, irq_q;

  always_comb begin
    taken = '0;
    hit   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      route_en[i] = !routes_i[i].dis && !RSVD_MASK[routes_i[i].num];
      err_o[i]    = route_en[i] && !ctl_i[routes_i[i].num];
      if (route_en[i]) begin
        taken[routes_i[i].num] = 1'b1;
        if (!line_n_i[i]) hit[routes_i[i].num] = 1'b1;  // invert active-low line
      end
    end
    irq_d = hit | (ser_req_i & (~taken | ser_low_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  for (genvar k = 0; k < IRQ_N; k++) begin : g_irq
    AST_HIGH_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (taken[k] && !ser_low_i[k] && !hit[k]) |=> !irq_o[k]); // R7
    AST_LOW_MERGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ser_req_i[k] && ser_low_i[k]) |=> irq_o[k]); // R8
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_LINES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [2:0]           wr_addr_i,
  input  logic [7:0]           wr_data_i,
  input  logic [NUM_LINES-1:0] pirq_n_i,
  input  logic [NUM_LINES-1:0] int_src_i,
  output logic [NUM_LINES-1:0] pirq_drv_o,
  input  logic [15:0]          ser_req_i,
  input  logic [15:0]          ser_low_i,
  output logic [15:0]          irq_o,
  output logic [NUM_LINES-1:0] route_err_o
);
  route_t [NUM_LINES-1:0] routes;
  logic   [IRQ_N-1:0]     ctl;
  logic   [NUM_LINES-1:0] line_n_s;
  logic   [IRQ_N-1:0]     ser_s;

  // on-chip sources pull the shared pad; the pad value comes back on pirq_n_i
  assign pirq_drv_o = int_src_i;

  pirq_regs #(.NUM_LINES(NUM_LINES)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .routes_o(routes), .ctl_o(ctl)
  );

  pirq_sync #(.W(NUM_LINES), .RST_VAL({NUM_LINES{1'b1}})) i_sync_line (
    .clk_i, .rst_ni, .d_i(pirq_n_i), .q_o(line_n_s)
  );

  pirq_sync #(.W(IRQ_N), .RST_VAL('0)) i_sync_ser (
    .clk_i, .rst_ni, .d_i(ser_req_i), .q_o(ser_s)
  );

  pirq_steer #(.NUM_LINES(NUM_LINES)) i_steer (
    .clk_i, .rst_ni,
    .routes_i(routes), .ctl_i(ctl), .line_n_i(line_n_s),
    .ser_req_i(ser_s), .ser_low_i(ser_low_i),
    .irq_o(irq_o), .err_o(route_err_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((&line_n_s) && ser_s == '0) |=> irq_o == '0); // R2

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    AST_LINE_TO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!routes[i].dis && !RSVD_MASK[routes[i].num] && !line_n_s[i]) |=> irq_o[$past(routes[i].num)]); // R2
    AST_FLAG_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      route_err_o[i] |-> (!routes[i].dis && !ctl[routes[i].num])); // R10
  end
endmodule

// File: tb/test_pirq_router.sv
module test_pirq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  ext_n = 4'hF;
  logic [3:0]  int_src = '0;
  logic [3:0]  drv;
  logic [3:0]  line_n;
  logic [15:0] ser_req = '0, ser_low = '0;
  logic [15:0] irq;
  logic [3:0]  rerr;
  int n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign line_n = ext_n & ~drv;  // wired-AND pad

  pirq_router i_pirq_router (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pirq_n_i(line_n), .int_src_i(int_src), .pirq_drv_o(drv),
    .ser_req_i(ser_req), .ser_low_i(ser_low), .irq_o(irq), .route_err_o(rerr)
  );

  // {line_n[51:48], ser_req[47:32], ser_low[31:16], expected irq[15:0]}
  // routes: A->5, B->5, C->10, D->13 (reserved)
  localparam logic [51:0] VEC [13] = '{
    {4'hF, 16'h0000, 16'h0000, 16'h0000},
    {4'hE, 16'h0000, 16'h0000, 16'h0020},
    {4'hD, 16'h0000, 16'h0000, 16'h0020},
    {4'hB, 16'h0000, 16'h0000, 16'h0400},
    {4'h7, 16'h0000, 16'h0000, 16'h0000},
    {4'h0, 16'h0000, 16'h0000, 16'h0420},
    {4'hF, 16'h0020, 16'h0000, 16'h0000},
    {4'hF, 16'h0020, 16'h0020, 16'h0020},
    {4'hF, 16'h0008, 16'h0000, 16'h0008},
    {4'hF, 16'h2000, 16'h0000, 16'h2000},
    {4'hB, 16'h0401, 16'h0000, 16'h0401},
    {4'hF, 16'h0400, 16'h0000, 16'h0000},
    {4'hE, 16'h0400, 16'h0400, 16'h0420}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", irq, 16'h0);
    check("R1 err/drv after reset", {8'h0, rerr, drv}, 16'h0);

    // R3 disabled route: line A low, nothing routed yet
    ext_n = 4'hE;
    repeat (4) @(negedge clk);
    check("R3 disabled route", irq, 16'h0);
    ext_n = 4'hF;

    wr(3'd0, 8'h05); wr(3'd1, 8'h05); wr(3'd2, 8'h0A); wr(3'd3, 8'h0D);
    check("R10 edge-mode targets flagged", {12'h0, rerr}, 16'h0007);
    wr(3'd4, 8'h20);
    check("R10 IRQ5 level, IRQ10 still edge", {12'h0, rerr}, 16'h0004);
    wr(3'd5, 8'h04);
    check("R9 R10 all level, no flag", {12'h0, rerr}, 16'h0000);

    for (int v = 0; v < 13; v++) begin
      @(negedge clk);
      ext_n = VEC[v][51:48]; ser_req = VEC[v][47:32]; ser_low = VEC[v][31:16];
      repeat (4) @(negedge clk);
      check($sformatf("R2 R4 R5 R7 R8 vector %0d", v), irq, VEC[v][15:0]);
    end
    ext_n = 4'hF; ser_req = '0; ser_low = '0;
    repeat (4) @(negedge clk);

    // R11 input latency: third rising edge after the change
    ext_n = 4'hE;
    @(negedge clk); @(negedge clk);
    check("R11 not yet after two edges", irq, 16'h0);
    @(negedge clk);
    check("R11 visible after third edge", irq, 16'h0020);

    // R11 route write latency: disable A while still low
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h85;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 old route one edge after write", irq, 16'h0020);
    @(negedge clk);
    check("R3 R11 disabled route drops", irq, 16'h0);
    ext_n = 4'hF;

    // R6 internal source on line C
    int_src = 4'b0100;
    @(negedge clk);
    check("R6 drive enable", {12'h0, drv}, 16'h0004);
    repeat (3) @(negedge clk);
    check("R6 internal source routed", irq, 16'h0400);
    int_src = '0;
    repeat (4) @(negedge clk);
    check("R6 release", irq, 16'h0);

    // R4 route to reserved IRQ 2 has no effect and no flag
    wr(3'd1, 8'h02);
    ext_n = 4'hD;
    repeat (4) @(negedge clk);
    check("R4 reserved target ignored", irq, 16'h0);
    check("R4 R10 reserved target not flagged", {12'h0, rerr}, 16'h0);
    ext_n = 4'hF;

    // R1 reset again restores defaults
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    ext_n = 4'hB;
    repeat (4) @(negedge clk);
    check("R1 routes cleared by reset", irq, 16'h0);
    ext_n = 4'hF;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule